// File: doc/BRIEF.md
# Eight-to-One Serializer with Sync and Freeze Control

The block turns an eight-bit parallel word into a serial bit stream, least-significant bit first. It also produces a word-frame clock that marks where each word sits in that stream. A mode input sets the rate:

- In one-bit mode the block sends one serial bit per clock on lane bit 0.
- In two-bit mode it sends a pair of bits per clock on a two-bit lane. This gives twice the clock-rate output.

A word is captured once per frame, at the frame boundary. Each mode has its own fixed delay from capture to the first output bit.

Two control inputs act on the whole block:

- **Sync input.** Raising it clears every flop at once, with no clock needed. Its release is taken only at a falling clock edge, so the first word after release starts cleanly.
- **Freeze input.** It is also sampled on falling edges. While it is sampled high, the whole datapath holds its state. When it is sampled low again, work resumes from that held state without losing or repeating a bit.

Top module: `ser8_serializer`

## Requirements
- R1: Within a word, bit 0 leaves first and bit 7 last. In two-bit mode `ser_o[0]` carries the earlier bit of each pair and `ser_o[1]` the later one.
- R2: With `mode_one`=1, one bit leaves per working clock on `ser_o[0]` and `ser_o[1]` stays 0. With `mode_one`=0, two bits leave per working clock, so a word takes 4 clocks instead of 8.
- R3: The first bit(s) of a captured word appear on `ser_o` after the 7th working rising edge following the capture edge in two-bit mode, or after the 14th in one-bit mode. Each word follows the previous one with no gap.
- R4: `frame_o` is high while the first half of a word's bits are on `ser_o` and low during the second half. This gives one period per 8 serial bits.
- R5: While `sync_rst` is high, all state is cleared and `ser_o` and `frame_o` read 0, without waiting for a clock edge.
- R6: After `sync_rst` falls, the block starts at the first falling clock edge that samples it low. The first capture happens on the next rising edge in two-bit mode, or on the second rising edge in one-bit mode.
- R7: `freeze` is sampled on every falling edge. A rising edge that follows a high sample changes nothing and the outputs stay stable. After a low sample, the stream continues with no bit lost or repeated.
- R8: `din` is captured only at the frame boundary. Values it takes between captures have no effect on the output.
- R9: After release, `ser_o` and `frame_o` stay 0 until the first captured bits come out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state updates on rising edges, controls sampled on falling edges |
| sync_rst | input | 1 | Active-high asynchronous clear, released at a falling edge |
| freeze | input | 1 | High suspends all activity, low resumes (falling-edge sampled) |
| mode_one | input | 1 | 1: one bit per clock, 0: two bits per clock; change only while `sync_rst` is high |
| din | input | 8 | Parallel word |
| ser_o | output | 2 | Serial lane; bit 0 only in one-bit mode |
| frame_o | output | 1 | Word-frame clock |

## Verification
The bench counts working rising edges itself: an edge is working when the last falling edge saw `sync_rst` low and `freeze` low, and in one-bit mode the first such edge is spent arming the block. At each capture edge it queues every pair of the word, with its due edge set to 7 or 14 working edges later plus its index. After each working edge the monitor pops the entry due on exactly that edge. When nothing is due yet it requires zeros, and on non-working edges it requires both outputs unchanged. Sync is raised between edges and the outputs are checked a nanosecond later, before any further edge.

// File: rtl/ser8_pkg.sv
package ser8_pkg;
  // One output beat: the serial lane and the frame level that travels with it.
  typedef struct packed {
    logic [1:0] lane;
    logic       frame;
  } ser8_beat_t;
endpackage

// File: rtl/ser8_ctrl.sv
// Falling-edge samplers for the sync release and the freeze request.
module ser8_ctrl (
  input  logic clk,
  input  logic sync_rst,
  input  logic freeze,
  output logic run_o,
  output logic hold_o
);
  logic run_q, hold_q;
  logic run_d, hold_d;

  always_comb begin
    run_d  = 1'b1;
    hold_d = freeze;
  end

  always_ff @(negedge clk or posedge sync_rst) begin
    if (sync_rst) begin
      run_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      hold_q <= hold_d;
    end
  end

  assign run_o  = run_q;
  assign hold_o = hold_q;

  // R7: no hold request can survive while the block is not yet released
  a_r7_hold_needs_run: assert property (@(negedge clk) disable iff (sync_rst)
    hold_q |-> run_q);
endmodule

// File: rtl/ser8_shifter.sv
// Frame slot counter, word capture and shift, frame-bit generation.
module ser8_shifter
  import ser8_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              sync_rst,
  input  logic              active,
  input  logic              mode_one,
  input  logic [WORD_W-1:0] din,
  output ser8_beat_t        beat_o,
  output logic              work_o
);
  localparam int FR_ONE = WORD_W;
  localparam int FR_TWO = WORD_W / 2;
  localparam int SW     = $clog2(WORD_W);

  logic              armed_q, armed_d;
  logic              loaded_q, loaded_d;
  logic [SW-1:0]     slot_q, slot_d;
  logic [SW-1:0]     pos_q, pos_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [SW-1:0]     fr_last, half;
  logic              work;

  always_comb begin
    fr_last  = mode_one ? SW'(FR_ONE - 1) : SW'(FR_TWO - 1);
    half     = mode_one ? SW'(FR_ONE / 2) : SW'(FR_TWO / 2);
    work     = active & (armed_q | ~mode_one);
    armed_d  = armed_q | active;
    loaded_d = loaded_q;
    pos_d    = pos_q;
    word_d   = word_q;
    slot_d   = slot_q;
    if (work) begin
      if (slot_q == '0) begin
        word_d   = din;
        loaded_d = 1'b1;
        pos_d    = '0;
      end else begin
        word_d = mode_one ? (word_q >> 1) : (word_q >> 2);
        pos_d  = pos_q + 1'b1;
      end
      slot_d = (slot_q == fr_last) ? '0 : slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or posedge sync_rst) begin
    if (sync_rst) begin
      armed_q <= 1'b0;
    end else if (active) begin
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk or posedge sync_rst) begin
    if (sync_rst) begin
      loaded_q <= 1'b0;
      slot_q   <= '0;
      pos_q    <= '0;
      word_q   <= '0;
    end else if (work) begin
      loaded_q <= loaded_d;
      slot_q   <= slot_d;
      pos_q    <= pos_d;
      word_q   <= word_d;
    end
  end

  always_comb begin
    beat_o.lane  = mode_one ? {1'b0, word_q[0]} : word_q[1:0];
    beat_o.frame = loaded_q & (pos_q < half);
  end
  assign work_o = work;

  // R8: a mid-frame shift only ever feeds zeros in at the top of the word
  a_r8_zero_fill: assert property (@(posedge clk) disable iff (sync_rst)
    work && slot_q != '0 |=> word_q[WORD_W-1] == 1'b0);
endmodule

// File: rtl/ser8_delay.sv
// Beat pipeline that sets the capture-to-output latency for each mode.
module ser8_delay
  import ser8_pkg::*;
#(
  parameter int LAT_ONE = 14,
  parameter int LAT_TWO = 7
) (
  input  logic       clk,
  input  logic       sync_rst,
  input  logic       en,
  input  logic       mode_one,
  input  ser8_beat_t beat_i,
  output ser8_beat_t beat_o
);
  localparam int DEPTH = (LAT_ONE > LAT_TWO) ? LAT_ONE : LAT_TWO;

  ser8_beat_t [DEPTH-1:0] stg_q;
  ser8_beat_t [DEPTH-1:0] stg_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign stg_d[i] = beat_i;
    end else begin : g_body
      assign stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or posedge sync_rst) begin
    if (sync_rst) begin
      stg_q <= '0;
    end else if (en) begin
      stg_q <= stg_d;
    end
  end

  assign beat_o = mode_one ? stg_q[LAT_ONE-1] : stg_q[LAT_TWO-1];

  // R7: a disabled pipeline keeps its output beat
  a_r7_pipe_hold: assert property (@(posedge clk) disable iff (sync_rst)
    !en |=> $stable(beat_o));
endmodule

// File: rtl/ser8_serializer.sv
module ser8_serializer
  import ser8_pkg::*;
#(
  parameter int WORD_W  = 8,
  parameter int LAT_TWO = 7,
  parameter int LAT_ONE = 14
) (
  input  logic              clk,
  input  logic              sync_rst,
  input  logic              freeze,
  input  logic              mode_one,
  input  logic [WORD_W-1:0] din,
  output logic [1:0]        ser_o,
  output logic              frame_o
);
  logic       run, hold, active, work;
  ser8_beat_t beat_sh, beat_out;

  ser8_ctrl u_ctrl (
    .clk      (clk),
    .sync_rst (sync_rst),
    .freeze   (freeze),
    .run_o    (run),
    .hold_o   (hold)
  );

  assign active = run & ~hold;

  ser8_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .sync_rst (sync_rst),
    .active   (active),
    .mode_one (mode_one),
    .din      (din),
    .beat_o   (beat_sh),
    .work_o   (work)
  );

  ser8_delay #(.LAT_ONE(LAT_ONE), .LAT_TWO(LAT_TWO)) u_delay (
    .clk      (clk),
    .sync_rst (sync_rst),
    .en       (work),
    .mode_one (mode_one),
    .beat_i   (beat_sh),
    .beat_o   (beat_out)
  );

  assign ser_o   = beat_out.lane;
  assign frame_o = beat_out.frame;

  // R7: outputs hold across any rising edge that does no work
  a_r7_frozen: assert property (@(posedge clk) disable iff (sync_rst)
    !work |=> $stable(ser_o) && $stable(frame_o));

  // R9: before release takes effect the outputs stay quiet
  a_r9_quiet: assert property (@(posedge clk) disable iff (sync_rst)
    !run |-> ser_o == 2'b00 && !frame_o);

  // R2: one-bit mode never drives the upper lane bit
  a_r2_upper_idle: assert property (@(posedge clk) disable iff (sync_rst)
    mode_one |-> ser_o[1] == 1'b0);
endmodule

// File: tb/ser8_serializer_test.sv
`timescale 1ns/1ps
module ser8_serializer_test;
  localparam int LAT2 = 7;
  localparam int LAT1 = 14;

  logic       clk = 1'b0;
  logic       sync_rst, freeze, mode_one;
  logic [7:0] din;
  logic [1:0] ser_o;
  logic       frame_o;

  ser8_serializer uut (
    .clk(clk), .sync_rst(sync_rst), .freeze(freeze), .mode_one(mode_one),
    .din(din), .ser_o(ser_o), .frame_o(frame_o)
  );

  always #5 clk = ~clk;

  typedef struct {
    int         due;
    logic [1:0] lane;
    logic       fr;
  } exp_t;
  exp_t q[$];

  int total = 0, bad = 0, popped = 0;
  bit run_m = 0, hold_m = 0, armed_m = 0;
  int slot_m = 0, wk = 0;
  logic [7:0] next_word;
  logic [1:0] prev_ser = 2'b00;
  logic       prev_fr = 1'b0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // falling-edge view of the controls (R6, R7)
  always @(negedge clk) begin
    run_m  = !sync_rst;
    hold_m = sync_rst ? 1'b0 : freeze;
  end

  // scoreboard: monitor then driver bookkeeping after every rising edge
  always @(posedge clk) begin
    bit act, work;
    int fr;
    act  = run_m && !hold_m;
    work = act && (armed_m || !mode_one);
    if (act) armed_m = 1;
    #2;
    if (work) begin
      wk++;
      if (q.size() > 0 && q[0].due == wk) begin
        chk("R1/R2/R3/R6/R8 lane", ser_o, q[0].lane);
        chk("R4 frame", {1'b0, frame_o}, {1'b0, q[0].fr});
        void'(q.pop_front());
        popped++;
      end else begin
        chk("R9 lane before first bits", ser_o, 2'b00);
        chk("R9 frame before first bits", {1'b0, frame_o}, 2'b00);
      end
      fr = mode_one ? 8 : 4;
      if (slot_m == 0) begin
        for (int j = 0; j < fr; j++) begin
          exp_t e;
          e.due  = wk + (mode_one ? LAT1 : LAT2) + j;
          e.lane = mode_one ? {1'b0, next_word[j]} : {next_word[2*j+1], next_word[2*j]};
          e.fr   = (j < fr / 2);
          q.push_back(e);
        end
        next_word = 8'($urandom);
      end
      slot_m = (slot_m == fr - 1) ? 0 : slot_m + 1;
      din = (slot_m == 0) ? next_word : 8'($urandom);
    end else begin
      chk("R7 lane stable", ser_o, prev_ser);
      chk("R7 frame stable", {1'b0, frame_o}, {1'b0, prev_fr});
    end
    prev_ser = ser_o;
    prev_fr  = frame_o;
  end

  task automatic run_cycles(input int n, input int freeze_pct);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      freeze = (($urandom % 100) < freeze_pct);
    end
    @(posedge clk);
    #1;
    freeze = 1'b0;
  endtask

  task automatic apply_sync(input logic new_mode);
    @(posedge clk);
    #3;
    sync_rst = 1'b1;
    #1;
    chk("R5 lane cleared at once", ser_o, 2'b00);
    chk("R5 frame cleared at once", {1'b0, frame_o}, 2'b00);
    q.delete();
    armed_m  = 0;
    slot_m   = 0;
    prev_ser = 2'b00;
    prev_fr  = 1'b0;
    freeze   = 1'b0;
    mode_one = new_mode;
    din      = next_word;
    repeat (3) @(posedge clk);
    #3;
    sync_rst = 1'b0;
  endtask

  initial begin
    sync_rst  = 1'b1;
    freeze    = 1'b0;
    mode_one  = 1'b0;
    next_word = 8'($urandom);
    din       = next_word;
    repeat (4) @(posedge clk);
    #4;
    chk("R5 lane in reset", ser_o, 2'b00);
    chk("R5 frame in reset", {1'b0, frame_o}, 2'b00);
    @(posedge clk);
    #3;
    sync_rst = 1'b0;
    run_cycles(120, 0);
    run_cycles(200, 25);
    apply_sync(1'b1);
    run_cycles(150, 0);
    run_cycles(250, 20);
    apply_sync(1'b0);
    run_cycles(200, 40);
    repeat (20) @(posedge clk);
    #4;
    total++;
    if (popped < 500) begin
      bad++;
      $display("FAIL R3 words streamed actual=%0d expected>=%0d", popped, 500);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule